// File: doc/BRIEF.md
# Systolic 3×3 Matrix Product Engine

This block forms the product C = A·B of two square signed integer matrices on a square mesh of processing elements (PEs). Each PE owns one entry of C and keeps it in a local accumulator for the whole computation. Entries of A enter each row of the mesh from the left edge and move one PE to the right per clock. Entries of B enter each column from the top edge and move one PE down per clock. On every clock each PE adds the product of the two operands that are passing through it.

A small edge controller holds both operand matrices, which are loaded in parallel when a start pulse is accepted. It then sends them into the mesh as staggered diagonal wavefronts. Row r of A and column c of B are each delayed by their own index, and zeros fill every slot that has no data. When the last wavefront has been used, the controller raises a done flag. The nine accumulators then stay on the result port until the next run. With the default size of three, one computation takes seven clocks.

Top module: `mesh_matmul`

## Requirements
- R1: When a start is accepted on a clock edge, done is low after that edge and rises exactly 3·N−2 clock edges later, which is 7 edges for N = 3.
- R2: Once done is high, result entry (r,c) equals the sum over k of A(r,k)·B(k,c). All values are two's complement. Entry (r,c) of every matrix port sits at flat index r·N+c. Operands take W bits at bit offset index·W. Results take CW = 2·W+$clog2(N) bits at bit offset index·CW, which is 2·W+2 bits for N = 3.
- R3: No result overflows. This includes the extreme case of every operand at −2^(W−1), and the case of A at +2^(W−1)−1 with B at −2^(W−1).
- R4: Every accumulator starts each run from zero, so a run does not depend on the results of the run before it.
- R5: A start that arrives while a computation is in progress is ignored, including a start on the final computing clock. Completion timing and results are the same as if that start had not arrived.
- R6: The operand ports are sampled only on the edge that accepts start. Changing them during a run has no effect on the results.
- R7: After completion, done and the results stay constant until a new start is accepted. A start while done is high begins a new run and clears done on the same edge.
- R8: After reset, done is low and all result entries read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a computation; accepted only when idle or done |
| a_mat | input | N·N·W | Left operand matrix, row-major, signed entries |
| b_mat | input | N·N·W | Right operand matrix, row-major, signed entries |
| done | output | 1 | High once results are complete, until the next accepted start |
| c_mat | output | N·N·CW | Product matrix, row-major, signed entries |

## Verification
Two events can fall on the same clock edge. One is the closing edge of a computation, where the controller retires and raises done. The other is a new start request. The bench raises start so that it is sampled on that final computing edge. It then checks three things: done still rises on schedule, no second run begins, and the results match the reference product. A second case drives start while done is already high. There the bench checks that done drops at once, and that the next product is correct and carries nothing over from the previous run.

// File: rtl/mesh_matmul_pkg.sv
package mesh_matmul_pkg;

   // Index of the operand that a lane carries on a given step.
   // A negative value means the lane holds padding (zero) on that step.
   function automatic int lane_offset(input int step, input int lane, input int n);
      int s;
      s = step - lane;
      if (s < 0 || s >= n) return -1;
      return s;
   endfunction

endpackage

// File: rtl/mesh_ctrl.sv
module mesh_ctrl #(
   parameter int STEPS = 7,
   parameter int SW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          load,
   output logic [SW-1:0] step
);

   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   assign load = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         step <= '0;
      end else if (load) begin
         busy <= 1'b1;
         done <= 1'b0;
         step <= '0;
      end else if (busy) begin
         if (step == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            step <= step + 1'b1;
         end
      end
   end

   // R1: completion only ever follows an active run
   a_r1_done_after_run : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R5: a start during a run neither restarts nor stalls the step sequence
   a_r5_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && step != LAST) |=> (busy && step == SW'($past(step) + 1'b1)));

   // R7: done persists until a start is taken
   a_r7_done_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R7: done and an active run never overlap
   a_r7_done_excl : assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

endmodule

// File: rtl/mesh_skew_feed.sv
module mesh_skew_feed
   import mesh_matmul_pkg::*;
#(
   parameter int N         = 3,
   parameter int W         = 8,
   parameter int SW        = 3,
   parameter bit COL_LANES = 1'b0
) (
   input  logic [N*N*W-1:0] mat,
   input  logic             busy,
   input  logic [SW-1:0]    step,
   output logic [N*W-1:0]   lanes
);

   for (genvar l = 0; l < N; l++) begin : g_lane
      always_comb begin
         int off;
         off = lane_offset(int'(step), l, N);
         lanes[l*W +: W] = '0;
         if (busy && off >= 0) begin
            if (COL_LANES)
               lanes[l*W +: W] = mat[(off*N + l)*W +: W];
            else
               lanes[l*W +: W] = mat[(l*N + off)*W +: W];
         end
      end
   end

endmodule

// File: rtl/mesh_pe.sv
module mesh_pe #(
   parameter int W  = 8,
   parameter int CW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic signed [W-1:0]  a_in,
   input  logic signed [W-1:0]  b_in,
   output logic signed [W-1:0]  a_out,
   output logic signed [W-1:0]  b_out,
   output logic signed [CW-1:0] acc
);

   logic signed [2*W-1:0] prod;
   logic signed [CW-1:0]  prod_ext;

   assign prod     = a_in * b_in;
   assign prod_ext = {{(CW-2*W){prod[2*W-1]}}, prod};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_out <= '0;
         b_out <= '0;
         acc   <= '0;
      end else if (clr) begin
         a_out <= '0;
         b_out <= '0;
         acc   <= '0;
      end else if (en) begin
         a_out <= a_in;
         b_out <= b_in;
         acc   <= acc + prod_ext;
      end
   end

   // R4: an accepted start empties the accumulator
   a_r4_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));

   // R7: outside a run the accumulator keeps its value
   a_r7_acc_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(acc));

endmodule

// File: rtl/mesh_matmul.sv
module mesh_matmul #(
   parameter int N = 3,
   parameter int W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [N*N*W-1:0]                  a_mat,
   input  logic [N*N*W-1:0]                  b_mat,
   output logic                              done,
   output logic [N*N*(2*W+$clog2(N))-1:0]    c_mat
);

   localparam int CW    = 2*W + $clog2(N);
   localparam int STEPS = 3*N - 2;
   localparam int SW    = $clog2(STEPS);

   if (N < 2) begin : g_bad_n
      $error("mesh_matmul: N must be at least 2");
   end
   if (W < 2) begin : g_bad_w
      $error("mesh_matmul: W must be at least 2");
   end

   logic          busy, load;
   logic [SW-1:0] step;
   logic [N*N*W-1:0] a_q, b_q;
   logic [N*W-1:0]   a_edge, b_edge;

   logic signed [W-1:0] a_h [N][N+1];
   logic signed [W-1:0] b_v [N+1][N];

   mesh_ctrl #(.STEPS(STEPS), .SW(SW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(done), .load(load), .step(step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= a_mat;
         b_q <= b_mat;
      end
   end

   mesh_skew_feed #(.N(N), .W(W), .SW(SW), .COL_LANES(1'b0)) u_feed_a (
      .mat(a_q), .busy(busy), .step(step), .lanes(a_edge)
   );

   mesh_skew_feed #(.N(N), .W(W), .SW(SW), .COL_LANES(1'b1)) u_feed_b (
      .mat(b_q), .busy(busy), .step(step), .lanes(b_edge)
   );

   for (genvar i = 0; i < N; i++) begin : g_edge
      assign a_h[i][0] = a_edge[i*W +: W];
      assign b_v[0][i] = b_edge[i*W +: W];
   end

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         logic signed [CW-1:0] acc;
         mesh_pe #(.W(W), .CW(CW)) u_pe (
            .clk(clk), .rst_n(rst_n), .clr(load), .en(busy),
            .a_in(a_h[r][c]), .b_in(b_v[r][c]),
            .a_out(a_h[r][c+1]), .b_out(b_v[r+1][c]),
            .acc(acc)
         );
         assign c_mat[(r*N + c)*CW +: CW] = acc;
      end
   end

   // R6: the held operands change only on an accepted start
   a_r6_operands_held : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(a_q) && $stable(b_q)));

   // R1: a start taken while idle is followed by a run
   a_r1_run_begins : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (busy && !done));

endmodule

// File: tb/mesh_matmul_test.sv
module mesh_matmul_test;

   localparam int N  = 3;
   localparam int W  = 8;
   localparam int CW = 2*W + $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N*N*W-1:0] a_mat = '0;
   logic [N*N*W-1:0] b_mat = '0;
   logic done;
   logic [N*N*CW-1:0] c_mat;

   int checks = 0;
   int errors = 0;
   int ma [N][N];
   int mb [N][N];

   mesh_matmul #(.N(N), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_mat(a_mat), .b_mat(b_mat), .done(done), .c_mat(c_mat)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint got(input int r, input int c);
      logic signed [CW-1:0] v;
      v = c_mat[(r*N + c)*CW +: CW];
      return longint'(v);
   endfunction

   function automatic longint ref_c(input int r, input int c);
      longint s = 0;
      for (int k = 0; k < N; k++) s += longint'(ma[r][k]) * longint'(mb[k][c]);
      return s;
   endfunction

   task automatic drive_inputs();
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            a_mat[(r*N + c)*W +: W] = W'(ma[r][c]);
            b_mat[(r*N + c)*W +: W] = W'(mb[r][c]);
         end
   endtask

   task automatic fill_random();
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            ma[r][c] = int'($urandom_range(0, 255)) - 128;
            mb[r][c] = int'($urandom_range(0, 255)) - 128;
         end
   endtask

   task automatic fill_const(input int va, input int vb);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            ma[r][c] = va;
            mb[r][c] = vb;
         end
   endtask

   task automatic check_results(input string req);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            chk(req, got(r, c), ref_c(r, c));
   endtask

   // One run: extra_at = after-edge index at which a stray start is raised (-1 none)
   task automatic run(input int extra_at, input bit mutate, input string req);
      longint keep;
      @(negedge clk);
      drive_inputs();
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R7 done cleared by start", longint'(done), 0);
      start = (extra_at == 0);
      for (int k = 1; k <= 3*N - 2; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == 3*N - 3) chk("R1 done low before last edge", longint'(done), 0);
         if (k == 3*N - 2) begin
            start = 1'b0;
            chk("R1 done on time", longint'(done), 1);
            check_results(req);
         end else begin
            start = (extra_at == k);
            if (mutate) begin
               a_mat = {$urandom, $urandom, $urandom};
               b_mat = {$urandom, $urandom, $urandom};
            end
         end
      end
      keep = got(N-1, N-1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R7 done held", longint'(done), 1);
      chk("R7 result held", got(N-1, N-1), keep);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20241));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8 done after reset", longint'(done), 0);
      for (int i = 0; i < N*N; i++)
         chk("R8 result after reset", longint'(c_mat[i*CW +: CW]), 0);
      rst_n = 1'b1;

      // R2: identity on the left returns B
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            ma[r][c] = (r == c) ? 1 : 0;
            mb[r][c] = r*N + c - 4;
         end
      run(-1, 1'b0, "R2 identity");

      // R2: single corner entries probe the skew alignment
      fill_const(0, 0);
      ma[0][2] = 5; mb[2][0] = -7; ma[2][0] = 3; mb[0][2] = 11;
      run(-1, 1'b0, "R2 corner skew");

      // R3: extremes
      fill_const(-128, -128);
      run(-1, 1'b0, "R3 most negative");
      fill_const(127, -128);
      run(-1, 1'b0, "R3 mixed extreme");

      // R2 / R4: random back-to-back runs
      for (int t = 0; t < 6; t++) begin
         fill_random();
         run(-1, 1'b0, "R2 R4 random");
      end

      // R4: a zero product right after a large one
      fill_const(0, 0);
      run(-1, 1'b0, "R4 zero after large");

      // R5: stray start mid-run and on the final computing edge
      fill_random();
      run(3, 1'b0, "R5 mid-run start");
      fill_random();
      run(3*N - 3, 1'b0, "R5 start on final edge");
      fill_random();
      run(0, 1'b0, "R5 start held over");

      // R6: operand ports changed during the run
      fill_random();
      run(-1, 1'b1, "R6 inputs changed");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule